// File: doc/BRIEF.md
# Packed-Lane Integer Add/Subtract Unit

This unit takes a pair of 64-bit operands and treats each one as a packed vector of equal-width integer elements. A single operation adds or subtracts every element pair at once. A size code inside the opcode sets the element width, and with it the number of elements. All elements are always processed, because no length register exists. Element k occupies bits [k*w +: w]. One shared byte-sliced carry chain does the work: at every element boundary the carry chain is cut, and the carry-in of the boundary byte is forced to the subtract value.

Four operation kinds are supported:
- wrap-around add;
- wrap-around subtract;
- saturating add;
- saturating subtract.

The saturating kinds clamp each element on its own, either as an unsigned value or as a signed value. An accepted operation produces a registered result one cycle later.

The output side is a two-state machine. In ST_EMPTY no result is presented. In ST_FULL a fresh result is presented with out_valid high. The transitions are:
- ST_EMPTY to ST_FULL (LOAD) when in_valid is high;
- ST_FULL to ST_FULL (RELOAD) when in_valid is high;
- ST_FULL to ST_EMPTY (DRAIN) when in_valid is low;
- ST_EMPTY to ST_EMPTY (IDLE) otherwise.

Top module: `simd_addsub_top`

## Requirements
- R1: in_op[1:0] selects the element width: 0 gives eight 8-bit elements, 1 gives four 16-bit elements, 2 gives two 32-bit elements and 3 gives one 64-bit element. Element k occupies bits [k*w +: w] of each operand and of the result.
- R2: When in_op[3:2]=0 (wrap add), each result element is (a+b) mod 2^w, and no carry passes into the neighbouring element.
- R3: When in_op[3:2]=1 (wrap subtract), each result element is (a-b) mod 2^w, and no borrow passes into the neighbouring element.
- R4: When in_op[3:2]=2 with in_op[4]=0 (unsigned saturating add), an element whose true sum exceeds 2^w-1 gives 2^w-1. Otherwise it gives the exact sum.
- R5: When in_op[3:2]=3 with in_op[4]=0 (unsigned saturating subtract), an element with a<b gives 0. Otherwise it gives a-b.
- R6: When in_op[4]=1 with a saturating kind, elements are two's-complement values. A true result above 2^(w-1)-1 gives that maximum, and a true result below -2^(w-1) gives that minimum.
- R7: For the wrap kinds, in_op[4] has no effect on the result.
- R8: An operation accepted with in_valid high appears on out_res with out_valid high at the next rising clock edge. After a cycle with in_valid low, out_valid is low and out_res keeps its previous value.
- R9: While rst_n is low, out_valid and out_res are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 5 | [1:0] element size, [3:2] operation kind, [4] signed saturation |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | out_res holds the result of the previous cycle's operation |
| out_res | output | 64 | Registered packed result |

## Verification
A wrong boundary decision in the carry chain shows up one cycle after the operation. It appears as a result element off by one, exactly where a lower element carried out or borrowed, so operands are chosen that force carries at every byte boundary under every size code. A wrong clamp decision also appears one cycle later, as a saturated value where an exact one was expected, or the reverse, so corner operands sit right on the signed and unsigned limits. A stuck or wrongly sequenced state register shows on out_valid, or on a result that is not held, in the cycle after any idle cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic [1:0] {
        KIND_ADD  = 2'd0,
        KIND_SUB  = 2'd1,
        KIND_SADD = 2'd2,
        KIND_SSUB = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } elem_size_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;
endpackage

// File: rtl/simd_carry_chain.sv
module simd_carry_chain #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [BYTES-1:0]  cout_o
);
    logic [BYTES-1:0] cut;

    // A byte starts a new element when its index is a multiple of the element byte count
    for (genvar g = 0; g < BYTES; g++) begin : g_cut
        assign cut[g] = ((g & ((1 << size_i) - 1)) == 0);
    end

    always_comb begin
        logic       cy;
        logic [8:0] part;
        cy     = sub_i;
        sum_o  = '0;
        cout_o = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (cut[i]) cy = sub_i;
            part = {1'b0, a_i[i*8 +: 8]} + {1'b0, b_i[i*8 +: 8] ^ {8{sub_i}}} + {8'd0, cy};
            sum_o[i*8 +: 8] = part[7:0];
            cout_o[i]       = part[8];
            cy              = part[8];
        end
    end
endmodule

// File: rtl/simd_clamp.sv
module simd_clamp #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] sum_i,
    input  logic [BYTES-1:0]  cout_i,
    input  logic [1:0]        size_i,
    input  logic              sub_i,
    input  logic              sat_i,
    input  logic              sgn_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        int   top;
        logic a_msb, b_msb, r_msb, ovf, is_top;
        logic [7:0] fill;
        res_o = sum_i;
        for (int i = 0; i < BYTES; i++) begin
            top = i | ((1 << size_i) - 1);
            if (top >= BYTES) top = BYTES - 1;
            is_top = (i == top);
            a_msb  = a_i[top*8 + 7];
            b_msb  = b_i[top*8 + 7] ^ sub_i;
            r_msb  = sum_i[top*8 + 7];
            fill   = sum_i[i*8 +: 8];
            if (sgn_i) begin
                ovf = (a_msb == b_msb) && (r_msb != a_msb);
                if (a_msb) fill = is_top ? 8'h80 : 8'h00;
                else       fill = is_top ? 8'h7F : 8'hFF;
            end else begin
                // add: carry out means overflow; sub: no carry means borrow
                ovf  = sub_i ? !cout_i[top] : cout_i[top];
                fill = sub_i ? 8'h00 : 8'hFF;
            end
            if (sat_i && ovf) res_o[i*8 +: 8] = fill;
        end
    end
endmodule

// File: rtl/simd_addsub_top.sv
module simd_addsub_top
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res
);
    out_state_t  state_q, state_d;
    op_kind_t    kind;
    elem_size_t  size;
    logic [DATA_W-1:0] sum, res;
    logic [BYTES-1:0]  cout;
    logic [DATA_W-1:0] res_q;

    assign kind = op_kind_t'(in_op[3:2]);
    assign size = elem_size_t'(in_op[1:0]);

    simd_carry_chain #(.DATA_W(DATA_W)) u_chain (
        .a_i    (in_a),
        .b_i    (in_b),
        .sub_i  (kind == KIND_SUB || kind == KIND_SSUB),
        .size_i (size),
        .sum_o  (sum),
        .cout_o (cout)
    );

    simd_clamp #(.DATA_W(DATA_W)) u_clamp (
        .a_i    (in_a),
        .b_i    (in_b),
        .sum_i  (sum),
        .cout_i (cout),
        .size_i (size),
        .sub_i  (kind == KIND_SUB || kind == KIND_SSUB),
        .sat_i  (kind == KIND_SADD || kind == KIND_SSUB),
        .sgn_i  (in_op[4]),
        .res_o  (res)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res;
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_res   = res_q;
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  in_op,
    input logic [63:0] in_a,
    input logic [63:0] in_b,
    input logic        out_valid,
    input logic [63:0] out_res
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res)); // R8
    AST_LOW_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[3:2] == 2'd0) |=> out_res[7:0] == 8'($past(in_a[7:0]) + $past(in_b[7:0]))); // R2
    AST_LOW_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[3:2] == 2'd1) |=> out_res[7:0] == 8'($past(in_a[7:0]) - $past(in_b[7:0]))); // R3
    AST_USAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 5'b01000) |=> out_res[7:0] >= $past(in_a[7:0])); // R4
    AST_USUB_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 5'b01100) |=> out_res[7:0] <= $past(in_a[7:0])); // R5
endmodule

bind simd_addsub_top simd_addsub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/sim_simd_addsub_top.sv
module sim_simd_addsub_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_res;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    simd_addsub_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] ref_op(logic [4:0] op, logic [63:0] a, logic [63:0] b);
        int w, n;
        logic [63:0] r;
        logic signed [67:0] ua, ub, s, mx, mn, msk;
        w   = 8 << op[1:0];
        n   = 64 / w;
        r   = '0;
        msk = (68'sd1 <<< w) - 68'sd1;
        for (int k = 0; k < n; k++) begin
            ua = $signed({4'd0, a >> (k*w)}) & msk;
            ub = $signed({4'd0, b >> (k*w)}) & msk;
            if (op[4] && op[3]) begin
                if (ua[w-1]) ua = ua - (68'sd1 <<< w);
                if (ub[w-1]) ub = ub - (68'sd1 <<< w);
                mx = (68'sd1 <<< (w-1)) - 68'sd1;
                mn = -(68'sd1 <<< (w-1));
            end else begin
                mx = msk;
                mn = 68'sd0;
            end
            s = op[2] ? ua - ub : ua + ub;
            if (op[3]) begin
                if (s > mx) s = mx;
                if (s < mn) s = mn;
            end
            r = r | (64'(s & msk) << (k*w));
        end
        return r;
    endfunction

    function automatic string tag(logic [4:0] op);
        case (op[3:2])
            2'd0: return op[4] ? "R2/R7/R1" : "R2/R1";
            2'd1: return op[4] ? "R3/R7/R1" : "R3/R1";
            default: return op[4] ? "R6/R1" : (op[2] ? "R5/R1" : "R4/R1");
        endcase
    endfunction

    task automatic apply(logic [4:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] exp;
        exp = ref_op(op, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        n_vec++;
        if (!out_valid || out_res !== exp) begin
            n_bad++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h/%b expected=%h/1",
                     tag(op), op, a, b, out_res, out_valid, exp);
        end
    endtask

    task automatic idle();
        logic [63:0] prev;
        prev = out_res;
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 5'b11111; in_a = $urandom; in_b = $urandom;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_res !== prev) begin
            n_bad++;
            $display("FAIL R8 idle actual=%h/%b expected=%h/0", out_res, out_valid, prev);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_res !== 64'd0) begin
            n_bad++;
            $display("FAIL R9 reset actual=%h/%b expected=0/0", out_res, out_valid);
        end
        rst_n = 1'b1;
        // carry stop at each boundary, every width
        for (int s = 0; s < 4; s++) begin
            apply(5'(s), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101); // R2
            apply(5'(4 | s), 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101); // R3
            apply(5'(8 | s), 64'hFF80_7F00_FFF0_8001, 64'h0180_8101_0011_8001); // R4
            apply(5'(12 | s), 64'h0080_7F00_FFF0_8001, 64'h0180_8101_0011_8001); // R5
            apply(5'(24 | s), 64'h7F80_7FFF_8000_7F80, 64'h0180_0180_0001_0180); // R6
            apply(5'(28 | s), 64'h8000_7F80_8000_7F80, 64'h0100_FF01_0001_80FF); // R6
            apply(5'(16 | s), 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF); // R7
        end
        idle();
        idle();
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) rb = ~ra;
            if ($urandom_range(0, 9) == 0) idle();
            apply(5'($urandom_range(0, 31)), ra, rb);
        end
        idle();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog actual=hung expected=complete");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule